// File: doc/BRIEF.md
# Tagged Register File with Rename Status

This block holds the architectural floating-point registers of a dynamically scheduled core. Next to each data word it keeps a producer tag. The tag names the reservation station that will deliver the register's next value, and zero means no write is pending. When an instruction issues, two source registers are looked up. Each lookup returns either a ready value or the tag of the station that will produce it. In the same cycle the destination register is renamed to the issuing station's tag. A later writer therefore supersedes any earlier producer, and write-after-read and write-after-write hazards on the register name go away.

Completed results arrive on a shared result bus as a data word plus the tag of the station that produced them. The block does not use register numbers for writeback. Every register whose producer tag equals the broadcast tag captures the data and returns to the blank state. A register that has been renamed to a newer producer keeps waiting for that newer producer. A lookup that meets a same-cycle broadcast of its producer gets the broadcast value at once. Lookup results are registered and appear one cycle after the issue.

Top module: `rename_regfile`

## Requirements
- R1: Synchronous active-high reset clears every register value to zero and every producer tag to 0 (blank). It also drives `op_valid` and all four operand outputs to zero.
- R2: A source whose producer tag is 0 returns its stored value with tag 0 on the operand outputs in the cycle after the issue, and `op_valid` is 1 in that cycle.
- R3: A source whose producer tag is nonzero, with no matching broadcast in the issue cycle, returns that tag and a value of zero.
- R4: An issue sets the destination's producer tag to `iss_tag` and replaces any earlier tag. A later broadcast of the earlier tag leaves that register unchanged.
- R5: A broadcast with a nonzero tag writes its data into every register whose producer tag equals it, and sets those tags to 0.
- R6: When an issue renames a register in the same cycle that a broadcast matches that register's current tag, the new tag is kept and the status is not cleared.
- R7: A source whose current producer tag equals a same-cycle nonzero broadcast returns the broadcast data with tag 0.
- R8: Source lookups see the state as it was before the same cycle's rename. A source equal to the destination therefore returns the previous value or producer.
- R9: A broadcast with tag 0, or with a tag that no register holds, changes no register. Registers with a blank tag are never written by a broadcast.
- R10: `op_valid` is 1 exactly in the cycle after a cycle with `iss_valid` high. The operand outputs change only in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| iss_dst | input | 4 | Destination register index to rename |
| iss_tag | input | 4 | Tag of the issuing station (nonzero) |
| res_valid | input | 1 | Result bus carries a broadcast |
| res_tag | input | 4 | Producer tag of the broadcast |
| res_data | input | 32 | Broadcast data |
| op_valid | output | 1 | Operand outputs hold a fresh lookup |
| op_a_value | output | 32 | First source value (zero when pending) |
| op_a_tag | output | 4 | First source producer tag (0 when ready) |
| op_b_value | output | 32 | Second source value (zero when pending) |
| op_b_tag | output | 4 | Second source producer tag (0 when ready) |

## Verification
The bench builds the block with its defaults: sixteen registers, 32-bit data and 4-bit tags. With these values all fifteen nonzero tags are in use during the fill phase, and the register index wraps back over tag 1. Small tag values allow one tag to be given to two registers on purpose, so that a single broadcast can be seen landing in several places. They also allow a superseded tag to be broadcast while its register waits on a newer producer. Every lookup result is predicted by a model of the register state that the bench builds from the requirements.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int RRF_NREG = 16;
  localparam int RRF_DW   = 32;
  localparam int RRF_TW   = 4;

  typedef enum logic [1:0] {
    SRC_STORED  = 2'd0,
    SRC_BUS     = 2'd1,
    SRC_PENDING = 2'd2
  } src_sel_e;
endpackage

// File: rtl/rrf_entry.sv
module rrf_entry #(
  parameter int DW = rrf_pkg::RRF_DW,
  parameter int TW = rrf_pkg::RRF_TW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rename_en,
  input  logic [TW-1:0] rename_tag,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] value,
  output logic [TW-1:0] status
);
  logic hit;

  assign hit = bus_valid && (bus_tag != '0) && (status == bus_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      value  <= '0;
      status <= '0;
    end else begin
      if (hit)
        value <= bus_data;
      if (rename_en)
        status <= rename_tag;
      else if (hit)
        status <= '0;
    end
  end

  AST_RENAME_WINS: assert property (@(posedge clk) disable iff (rst)
    rename_en |=> status == $past(rename_tag)); // R6

  AST_MATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!rename_en && hit) |=> (status == '0) && (value == $past(bus_data))); // R5

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!rename_en && !hit) |=> $stable(status) && $stable(value)); // R9
endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port #(
  parameter int NREG = rrf_pkg::RRF_NREG,
  parameter int DW   = rrf_pkg::RRF_DW,
  parameter int TW   = rrf_pkg::RRF_TW,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [AW-1:0]            idx,
  input  logic [NREG-1:0][DW-1:0]  vals,
  input  logic [NREG-1:0][TW-1:0]  tags,
  input  logic                     bus_valid,
  input  logic [TW-1:0]            bus_tag,
  input  logic [DW-1:0]            bus_data,
  output logic [DW-1:0]            out_value,
  output logic [TW-1:0]            out_tag
);
  import rrf_pkg::*;

  logic [DW-1:0] sel_val;
  logic [TW-1:0] sel_tag;
  src_sel_e      sel;

  always_comb begin
    sel_val = vals[idx];
    sel_tag = tags[idx];
    if (sel_tag == '0)
      sel = SRC_STORED;
    else if (bus_valid && (bus_tag == sel_tag))
      sel = SRC_BUS;
    else
      sel = SRC_PENDING;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_value <= '0;
      out_tag   <= '0;
    end else if (en) begin
      unique case (sel)
        SRC_STORED:  begin out_value <= sel_val;  out_tag <= '0;      end
        SRC_BUS:     begin out_value <= bus_data; out_tag <= '0;      end
        default:     begin out_value <= '0;       out_tag <= sel_tag; end
      endcase
    end
  end

  AST_READY_VALUE: assert property (@(posedge clk) disable iff (rst)
    (en && tags[idx] == '0) |=> (out_tag == '0) && (out_value == $past(vals[idx]))); // R2

  AST_PENDING_TAG: assert property (@(posedge clk) disable iff (rst)
    (en && tags[idx] != '0 && !(bus_valid && bus_tag == tags[idx]))
      |=> (out_tag == $past(tags[idx])) && (out_value == '0)); // R3

  AST_BUS_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (en && tags[idx] != '0 && bus_valid && bus_tag == tags[idx])
      |=> (out_tag == '0) && (out_value == $past(bus_data))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_value) && $stable(out_tag)); // R10
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile #(
  parameter int NREG = rrf_pkg::RRF_NREG,
  parameter int DW   = rrf_pkg::RRF_DW,
  parameter int TW   = rrf_pkg::RRF_TW,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [AW-1:0] iss_src_a,
  input  logic [AW-1:0] iss_src_b,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_data,
  output logic          op_valid,
  output logic [DW-1:0] op_a_value,
  output logic [TW-1:0] op_a_tag,
  output logic [DW-1:0] op_b_value,
  output logic [TW-1:0] op_b_tag
);
  logic [NREG-1:0][DW-1:0] ent_val;
  logic [NREG-1:0][TW-1:0] ent_tag;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    rrf_entry #(.DW(DW), .TW(TW)) u_ent (
      .clk        (clk),
      .rst        (rst),
      .rename_en  (iss_valid && (iss_dst == AW'(g))),
      .rename_tag (iss_tag),
      .bus_valid  (res_valid),
      .bus_tag    (res_tag),
      .bus_data   (res_data),
      .value      (ent_val[g]),
      .status     (ent_tag[g])
    );
  end

  rrf_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd_a (
    .clk(clk), .rst(rst), .en(iss_valid), .idx(iss_src_a),
    .vals(ent_val), .tags(ent_tag),
    .bus_valid(res_valid), .bus_tag(res_tag), .bus_data(res_data),
    .out_value(op_a_value), .out_tag(op_a_tag)
  );

  rrf_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd_b (
    .clk(clk), .rst(rst), .en(iss_valid), .idx(iss_src_b),
    .vals(ent_val), .tags(ent_tag),
    .bus_valid(res_valid), .bus_tag(res_tag), .bus_data(res_data),
    .out_value(op_b_value), .out_tag(op_b_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) op_valid <= 1'b0;
    else     op_valid <= iss_valid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> op_valid); // R10

  AST_VALID_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !op_valid); // R10

  AST_TAG_XOR_VALUE_A: assert property (@(posedge clk) disable iff (rst)
    (op_a_tag != '0) |-> (op_a_value == '0)); // R3
endmodule

// File: tb/test_rename_regfile.sv
`timescale 1ns/1ps
module test_rename_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0, iss_tag = '0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_tag = '0;
  logic [31:0] res_data = '0;
  logic        op_valid;
  logic [31:0] op_a_value, op_b_value;
  logic [3:0]  op_a_tag, op_b_tag;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] av; logic [3:0] at;
    logic [31:0] bv; logic [3:0] bt;
    string       lbl;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_val[16];
  logic [3:0]  m_tag[16];

  always #10 clk = ~clk;

  rename_regfile i_rename_regfile (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .op_valid(op_valid), .op_a_value(op_a_value), .op_a_tag(op_a_tag),
    .op_b_value(op_b_value), .op_b_tag(op_b_tag)
  );

  task automatic check(input bit ok, input string lbl, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", lbl, what, act, expv);
    end
  endtask

  function automatic void predict(input logic [3:0] r, input bit bv, input logic [3:0] bt,
                                  input logic [31:0] bd, output logic [31:0] v, output logic [3:0] t);
    if (m_tag[r] == 4'd0) begin v = m_val[r]; t = 4'd0; end
    else if (bv && bt == m_tag[r]) begin v = bd; t = 4'd0; end
    else begin v = 32'd0; t = m_tag[r]; end
  endfunction

  task automatic step(input bit iv, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] d, input logic [3:0] t,
                      input bit bv, input logic [3:0] bt, input logic [31:0] bd,
                      input string lbl);
    exp_t e;
    @(negedge clk);
    iss_valid = iv; iss_src_a = a; iss_src_b = b; iss_dst = d; iss_tag = t;
    res_valid = bv; res_tag = bt; res_data = bd;
    if (iv) begin
      predict(a, bv, bt, bd, e.av, e.at);
      predict(b, bv, bt, bd, e.bv, e.bt);
      e.lbl = lbl;
      exp_q.push_back(e);
    end
    for (int i = 0; i < 16; i++) begin
      bit hit;
      hit = bv && (bt != 4'd0) && (m_tag[i] == bt);
      if (hit) m_val[i] = bd;
      if (iv && d == 4'(i)) m_tag[i] = t;
      else if (hit) m_tag[i] = 4'd0;
    end
  endtask

  // monitor: pops one expected lookup per op_valid pulse
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        if (op_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected op_valid", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(op_a_value == e.av, e.lbl, "a value", op_a_value, e.av);
            check(op_a_tag   == e.at, e.lbl, "a tag",   32'(op_a_tag), 32'(e.at));
            check(op_b_value == e.bv, e.lbl, "b value", op_b_value, e.bv);
            check(op_b_tag   == e.bt, e.lbl, "b tag",   32'(op_b_tag), 32'(e.bt));
          end
        end else if (exp_q.size() != 0) begin
          check(1'b0, "R10", "missing op_valid", 32'd0, 32'd1);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = '0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check(op_valid == 1'b0, "R1", "op_valid", 32'(op_valid), 32'd0);
    check(op_a_value == '0 && op_b_value == '0, "R1", "values", op_a_value | op_b_value, 32'd0);
    check(op_a_tag == '0 && op_b_tag == '0, "R1", "tags", 32'(op_a_tag | op_b_tag), 32'd0);
    // R1 stored state after reset, read through lookup
    step(1, 4'd0, 4'd15, 4'd0, 4'd1, 0, 4'd0, 32'd0, "R1 reset regs");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'd1, 32'd0, "R5 clear");
    // fill: rename each register, then broadcast its result (R8 src==dst)
    for (int r = 0; r < 16; r++) begin
      step(1, 4'(r), 4'((r + 1) % 16), 4'(r), 4'((r % 15) + 1), 0, 4'd0, 32'd0, "R2 R8 fill");
      step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'((r % 15) + 1), 32'hA000_0000 + 32'(r * 17), "R5 fill");
    end
    step(1, 4'd3, 4'd12, 4'd15, 4'd6, 0, 4'd0, 32'd0, "R2 stored values");
    // R3 pending producer
    step(1, 4'd4, 4'd4, 4'd4, 4'd7, 0, 4'd0, 32'd0, "R8 old value");
    step(1, 4'd4, 4'd15, 4'd10, 4'd8, 0, 4'd0, 32'd0, "R3 pending tag");
    // R4 supersede then broadcast the stale tag
    step(1, 4'd4, 4'd1, 4'd4, 4'd9, 1, 4'd7, 32'hDEAD_0007, "R4 supersede");
    step(1, 4'd4, 4'd4, 4'd11, 4'd10, 0, 4'd0, 32'd0, "R4 stale ignored");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'd9, 32'h0000_9999, "R4 real producer");
    step(1, 4'd4, 4'd10, 4'd11, 4'd10, 0, 4'd0, 32'd0, "R4 value landed");
    // R5 one tag, two registers
    step(1, 4'd0, 4'd1, 4'd5, 4'd2, 0, 4'd0, 32'd0, "R5 setup");
    step(1, 4'd0, 4'd1, 4'd6, 4'd2, 0, 4'd0, 32'd0, "R5 setup");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'd2, 32'h5555_AAAA, "R5 broadcast");
    step(1, 4'd5, 4'd6, 4'd7, 4'd3, 0, 4'd0, 32'd0, "R5 both written");
    // R6 rename beats same-cycle clear
    step(1, 4'd0, 4'd1, 4'd8, 4'd11, 0, 4'd0, 32'd0, "R6 setup");
    step(1, 4'd2, 4'd3, 4'd8, 4'd12, 1, 4'd11, 32'h1111_2222, "R6 race");
    step(1, 4'd8, 4'd0, 4'd2, 4'd4, 0, 4'd0, 32'd0, "R6 new tag kept");
    // R7 bypass of completing producer
    step(1, 4'd0, 4'd1, 4'd9, 4'd13, 0, 4'd0, 32'd0, "R7 setup");
    step(1, 4'd9, 4'd8, 4'd1, 4'd5, 1, 4'd13, 32'hB1B1_B1B1, "R7 bypass");
    // R8 source equals destination while pending
    step(1, 4'd9, 4'd9, 4'd9, 4'd14, 0, 4'd0, 32'd0, "R8 src is dst");
    step(1, 4'd9, 4'd0, 4'd0, 4'd15, 0, 4'd0, 32'd0, "R8 renamed");
    // R9 tag 0 and unused tag broadcasts
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'd0, 32'hFFFF_FFFF, "R9 tag zero");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 1, 4'd1, 32'hEEEE_EEEE, "R9 unused tag");
    step(1, 4'd3, 4'd12, 4'd3, 4'd1, 0, 4'd0, 32'd0, "R9 blanks untouched");
    // R10 idle gap, then final sweep of all registers
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 0, 4'd0, 32'd0, "R10 idle");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 0, 4'd0, 32'd0, "R10 idle");
    for (int r = 0; r < 16; r += 2)
      step(1, 4'(r), 4'(r + 1), 4'd14, 4'd6, 0, 4'd0, 32'd0, "R5 R9 sweep");
    step(0, 4'd0, 4'd0, 4'd0, 4'd0, 0, 4'd0, 32'd0, "end");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pending lookups", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule